// File: doc/BRIEF.md
# Standard-definition line, field and subcarrier timing controller

This block keeps the raster position of a standard-definition encoder: a pixel counter within the line, a line counter within the field, and a field number that runs through a four-field sequence for 525-line systems or an eight-field sequence for 625-line systems. It also keeps a 32-bit subcarrier phase accumulator that advances by a programmable increment on every clock. The increment is written as four bytes and takes effect only when the last byte arrives.

A single external control pin serves one of three purposes, picked by a 2-bit mode input. It can hold the raster counters in reset. It can arm a zeroing of the subcarrier phase at the next field start. It can carry a serial real-time-control frame whose payload replaces the increment at the next line boundary. An option lets the counters follow an incoming vertical sync instead of their nominal lengths. This keeps the output fields whole when the source plays faster or slower than normal. The option is refused when the block works in slave mode 0.

Top module: `sd_sync_phase_ctl`

## Requirements
- R1: After reset the pixel and line counters read 0, the field number reads 1, the phase reads 0, and the programmed increment is 0x21F07C1E. The first clock after reset therefore moves the phase to 0x21F07C1E.
- R2: The pixel counter wraps from CLKS_PER_LINE-1 to 0. The line counter wraps at LINES_NTSC lines when `pal_en`=0 and at LINES_PAL lines when `pal_en`=1. The field number then steps 1..4 (`pal_en`=0) or 1..8 (`pal_en`=1) and returns to 1.
- R3: With `pin_mode`=00, the pin is registered once. Each clock edge that sees the registered pin high forces pixel 0, line 0, field 1 and phase 0. A one-clock pulse is enough. After release, counting and the phase resume from that origin.
- R4: With `pin_mode`=01, a rising edge on the pin arms a one-shot. At the next field start the phase reads 0 instead of advancing, and the field number still advances. Later field starts are not affected.
- R5: On every other clock the phase grows by the active increment, modulo 2^32. The active increment is the real-time-control increment when `pin_mode`=10, and the programmed word in every other mode.
- R6: A write with `fsc_sel` 0, 1 or 2 stores a byte (bits 7:0, 15:8 or 23:16) without changing the increment. A write with `fsc_sel`=3 supplies bits 31:24 and makes the whole word active from the next clock.
- R7: With `pin_mode`=10, a frame starts on a rising edge of the pin. That marker is held for two clocks and is followed by 67 bits, each held for two clocks, bit 0 first. Bits 0..21 become increment bits 31:10, and increment bits 9:0 are zero. Bits 22..66, and any rising edges inside the frame, are ignored. The increment in this mode is 0 until the first frame completes.
- R8: A completed frame changes the increment at the first line boundary after it completes. The clock that wraps the pixel counter still uses the old increment, and the next clock uses the new one.
- R9: With `vcr_en`=1 and `slave0`=0, a rising edge on `vsync_in` (registered once) sets pixel 0 and line 0 and advances the field number. Without it, the line counter stays on the last line and the field number does not advance.
- R10: With `slave0`=1 or `vcr_en`=0, `vsync_in` has no effect and the counters keep their nominal lengths.
- R11: With `pin_mode`=11, the control pin has no effect on the counters or the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 2 | Pin use: 00 timing reset, 01 phase reset, 10 serial control, 11 none |
| ctl_pin | input | 1 | Multi-purpose control pin |
| pal_en | input | 1 | 1 selects the 625-line lengths and eight-field sequence |
| vcr_en | input | 1 | Follow incoming vertical sync |
| slave0 | input | 1 | Slave mode 0 active; disables sync following |
| vsync_in | input | 1 | Incoming vertical sync |
| fsc_wr | input | 1 | Increment byte write strobe |
| fsc_sel | input | 2 | Byte lane of the write |
| fsc_byte | input | 8 | Byte value |
| h_cnt | output | $clog2(CLKS_PER_LINE) | Pixel position in line |
| v_cnt | output | $clog2(max lines) | Line position in field |
| field_num | output | 4 | Field number, from 1 |
| phase | output | 32 | Subcarrier phase accumulator |

## Verification
The armed phase zeroing and the sync-driven field restart can land on the same clock edge. This happens when the field start in sync-following mode comes from `vsync_in` while a phase reset is pending. The bench arms the reset with a pin pulse and then raises `vsync_in` in the middle of a line. It expects pixel 0, line 0, the next field number and a zero phase all after the same edge, followed by a normal increment step. A second meeting point is a serial frame that completes just before a line wrap. The bench finds the wrap from the pixel output and expects the old increment on the wrapping clock and the new one on the clock after.

// File: rtl/sd_sync_phase_ctl.sv
module sd_sync_phase_ctl #(
  parameter int CLKS_PER_LINE = 1716,
  parameter int LINES_NTSC = 263,
  parameter int LINES_PAL = 313,
  parameter logic [31:0] FSC_RESET = 32'h21F07C1E,
  parameter int RTC_BITS = 67,
  parameter int RTC_INC_BITS = 22,
  localparam int HW = $clog2(CLKS_PER_LINE),
  localparam int LMAX = (LINES_PAL > LINES_NTSC) ? LINES_PAL : LINES_NTSC,
  localparam int VW = $clog2(LMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pin_mode,
  input  logic          ctl_pin,
  input  logic          pal_en,
  input  logic          vcr_en,
  input  logic          slave0,
  input  logic          vsync_in,
  input  logic          fsc_wr,
  input  logic [1:0]    fsc_sel,
  input  logic [7:0]    fsc_byte,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic [3:0]    field_num,
  output logic [31:0]   phase
);
  localparam int RTC_LAST = 2 * RTC_BITS + 1;
  localparam int CW = $clog2(RTC_LAST + 1);
  localparam int SAMP_END = 3 + 2 * RTC_INC_BITS;
  localparam logic [1:0] M_TRST = 2'b00, M_SCR = 2'b01, M_RTC = 2'b10;

  logic pin_r, pin_p, vs_r, vs_p;
  logic [31:0] inc_reg, rtc_inc;
  logic [23:0] fsc_low;
  logic [RTC_INC_BITS-1:0] rx_sr, rtc_new;
  logic rx_busy, rtc_pend, scr_pend;
  logic [CW-1:0] rx_cnt;

  wire pin_rise = pin_r & ~pin_p;
  wire vs_start = vs_r & ~vs_p;
  wire tr_hold = (pin_mode == M_TRST) & pin_r;
  wire vcr_on = vcr_en & ~slave0;
  wire line_end = h_cnt == HW'(CLKS_PER_LINE - 1);
  wire [VW-1:0] v_last = pal_en ? VW'(LINES_PAL - 1) : VW'(LINES_NTSC - 1);
  wire [3:0] f_last = pal_en ? 4'd8 : 4'd4;
  wire at_v_last = v_cnt >= v_last;
  wire [3:0] f_next = (field_num >= f_last) ? 4'd1 : field_num + 4'd1;
  wire f_start = vcr_on ? vs_start : (line_end & at_v_last);
  wire scr_zero = (pin_mode == M_SCR) & scr_pend & f_start;
  wire [31:0] inc_cur = (pin_mode == M_RTC) ? rtc_inc : inc_reg;
  wire rx_sample = rx_busy & rx_cnt[0] & (rx_cnt >= CW'(3)) & (rx_cnt < CW'(SAMP_END));
  wire rx_done = rx_busy & (rx_cnt == CW'(RTC_LAST));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pin_r, pin_p, vs_r, vs_p} <= '0;
    else {pin_r, pin_p, vs_r, vs_p} <= {ctl_pin, pin_r, vsync_in, vs_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0; v_cnt <= '0; field_num <= 4'd1;
    end else if (tr_hold) begin
      h_cnt <= '0; v_cnt <= '0; field_num <= 4'd1;
    end else if (vcr_on && vs_start) begin
      h_cnt <= '0; v_cnt <= '0; field_num <= f_next;
    end else begin
      h_cnt <= line_end ? '0 : h_cnt + 1'b1;
      if (line_end) begin
        if (!at_v_last) v_cnt <= v_cnt + 1'b1;
        else if (!vcr_on) begin
          v_cnt <= '0; field_num <= f_next;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else if (tr_hold || scr_zero) phase <= '0;
    else phase <= phase + inc_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scr_pend <= 1'b0;
    else if (pin_mode != M_SCR) scr_pend <= 1'b0;
    else if (f_start) scr_pend <= pin_rise;
    else if (pin_rise) scr_pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc_reg <= FSC_RESET; fsc_low <= '0;
    end else if (fsc_wr) begin
      if (fsc_sel == 2'd3) inc_reg <= {fsc_byte, fsc_low};
      else fsc_low[fsc_sel*8 +: 8] <= fsc_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_cnt <= '0; rx_sr <= '0;
      rtc_new <= '0; rtc_pend <= 1'b0; rtc_inc <= '0;
    end else if (pin_mode != M_RTC) begin
      rx_busy <= 1'b0; rtc_pend <= 1'b0;
    end else begin
      if (line_end && rtc_pend) begin
        rtc_inc <= {rtc_new, (32 - RTC_INC_BITS)'(0)};
        rtc_pend <= 1'b0;
      end
      if (!rx_busy && pin_rise) begin
        rx_busy <= 1'b1; rx_cnt <= CW'(1);
      end else if (rx_busy) begin
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_sample) rx_sr <= {pin_r, rx_sr[RTC_INC_BITS-1:1]};
        if (rx_done) begin
          rx_busy <= 1'b0; rtc_new <= rx_sr; rtc_pend <= 1'b1;
        end
      end
    end
  end

  always_comb
    if (rst_n) p_field_range_r2: assert (field_num >= 4'd1 && field_num <= 4'd8);

  p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_end && !tr_hold |=> h_cnt == '0);
  p_h_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end && !tr_hold && !(vcr_on && vs_start) |=> h_cnt == $past(h_cnt) + 1'b1);
  p_hold_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tr_hold |=> h_cnt == '0 && v_cnt == '0 && field_num == 4'd1 && phase == '0);
  p_scr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scr_zero |=> phase == '0 && field_num != $past(field_num));
  p_phase_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_hold && !scr_zero |=> phase == $past(phase) + $past(inc_cur));
  p_partial_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fsc_wr && fsc_sel != 2'd3 |=> $stable(inc_reg));
  p_rtc_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(rtc_inc));
  p_vcr_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vcr_on && !vs_start && !tr_hold && line_end && at_v_last
    |=> $stable(v_cnt) && $stable(field_num));
endmodule

// File: tb/sd_sync_phase_ctl_tb_top.sv
module sd_sync_phase_ctl_tb_top;
  localparam int CPL = 8, LN = 3, LP = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pin_mode = 2'b11;
  logic ctl_pin = 0, pal_en = 0, vcr_en = 0, slave0 = 0, vsync_in = 0;
  logic fsc_wr = 0;
  logic [1:0] fsc_sel = 0;
  logic [7:0] fsc_byte = 0;
  logic [2:0] h_cnt;
  logic [1:0] v_cnt;
  logic [3:0] field_num;
  logic [31:0] phase;

  sd_sync_phase_ctl #(.CLKS_PER_LINE(CPL), .LINES_NTSC(LN), .LINES_PAL(LP)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .ctl_pin(ctl_pin), .pal_en(pal_en),
    .vcr_en(vcr_en), .slave0(slave0), .vsync_in(vsync_in), .fsc_wr(fsc_wr),
    .fsc_sel(fsc_sel), .fsc_byte(fsc_byte), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .field_num(field_num), .phase(phase));

  always #5 clk = ~clk;

  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t q[$];
  int checks = 0, errors = 0, n = 0, fbase = 1;
  bit done = 0;
  logic [31:0] cur_inc = 32'h21F07C1E, p0;

  task automatic push(string r, int s, logic [31:0] e);
    item_t it;
    it.req = r; it.sel = s; it.exp = e;
    q.push_back(it);
  endtask

  task automatic tick(int k);
    repeat (k) begin @(posedge clk); #1; n++; end
  endtask

  task automatic exp_pos(string r);
    int lpf, nf;
    lpf = pal_en ? LP : LN;
    nf = pal_en ? 8 : 4;
    push(r, 0, n % CPL);
    push(r, 1, (n / CPL) % lpf);
    push(r, 2, ((n / (CPL * lpf)) + fbase - 1) % nf + 1);
  endtask

  task automatic step_phase(string r, logic [31:0] inc);
    p0 = phase;
    tick(1);
    push(r, 3, p0 + inc);
  endtask

  task automatic timing_reset_pulse();
    pin_mode = 2'b00; ctl_pin = 1; tick(1); ctl_pin = 0; tick(1);
    n = 0; fbase = 1;
  endtask

  task automatic wr_byte(logic [1:0] s, logic [7:0] b);
    fsc_wr = 1; fsc_sel = s; fsc_byte = b; tick(1); fsc_wr = 0;
  endtask

  task automatic send_rtc(logic [21:0] v);
    ctl_pin = 0; tick(1);
    ctl_pin = 1; tick(2);
    for (int k = 0; k < 67; k++) begin
      ctl_pin = (k < 22) ? v[k] : (k % 3 == 0);
      tick(2);
    end
    ctl_pin = 0;
  endtask

  // scoreboard monitor
  initial forever begin
    @(posedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = 32'(h_cnt);
        1: act = 32'(v_cnt);
        2: act = 32'(field_num);
        default: act = phase;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [21:0] v1;
    tick(3);
    push("R1", 0, 0); push("R1", 1, 0); push("R1", 2, 1); push("R1", 3, 0);
    tick(1);
    rst_n = 1; n = 0; fbase = 1;
    step_phase("R1", 32'h21F07C1E);
    // R2 nominal NTSC counting
    tick(22 - n + 1); exp_pos("R2");
    tick(1); exp_pos("R2");
    tick(95 - n); exp_pos("R2");
    tick(1); exp_pos("R2");
    // R3 one-clock pulse, then R2 for PAL lengths
    pal_en = 1;
    timing_reset_pulse();
    push("R3", 0, 0); push("R3", 1, 0); push("R3", 2, 1); push("R3", 3, 0);
    step_phase("R3", cur_inc); exp_pos("R3");
    tick(31 - n); exp_pos("R2");
    tick(1); exp_pos("R2");
    tick(255 - n); exp_pos("R2");
    tick(1); exp_pos("R2");
    // R3 long hold
    pal_en = 0;
    tick(5);
    ctl_pin = 1; tick(2);
    push("R3", 0, 0); push("R3", 2, 1); push("R3", 3, 0);
    tick(5);
    push("R3", 0, 0); push("R3", 1, 0); push("R3", 3, 0);
    ctl_pin = 0; tick(1);
    push("R3", 0, 0); push("R3", 3, 0);
    n = 0; fbase = 1;
    tick(1); exp_pos("R3"); push("R3", 3, cur_inc);
    // R11 pin ignored
    pin_mode = 2'b11;
    ctl_pin = 1; tick(3); ctl_pin = 0; tick(2);
    exp_pos("R11");
    step_phase("R11", cur_inc);
    // R6 byte-wise increment
    wr_byte(2'd0, 8'h04); wr_byte(2'd1, 8'h03); wr_byte(2'd2, 8'h02);
    step_phase("R6", cur_inc);
    wr_byte(2'd3, 8'h01);
    cur_inc = 32'h01020304;
    step_phase("R6", cur_inc);
    // R4 subcarrier phase reset at next field start
    timing_reset_pulse();
    pin_mode = 2'b01;
    tick(1);
    ctl_pin = 1; tick(1); ctl_pin = 0;
    tick(22 - n);
    step_phase("R4", cur_inc); exp_pos("R4");
    tick(1);
    push("R4", 3, 0); exp_pos("R4");
    step_phase("R4", cur_inc);
    tick(47 - n);
    step_phase("R4", cur_inc); exp_pos("R4");
    // R9 + R4 same edge: VSYNC-driven field start consumes armed reset
    vcr_en = 1;
    ctl_pin = 1; tick(1); ctl_pin = 0; tick(1);
    vsync_in = 1; tick(1); vsync_in = 0;
    push("R9", 2, 3);
    tick(1);
    push("R9", 0, 0); push("R9", 1, 0); push("R9", 2, 4); push("R4", 3, 0);
    step_phase("R4", cur_inc);
    tick(39);
    push("R9", 0, 0); push("R9", 1, 2); push("R9", 2, 4);
    vsync_in = 1; tick(1); vsync_in = 0; tick(1);
    push("R9", 0, 0); push("R9", 1, 0); push("R9", 2, 1);
    n = 0; fbase = 1;
    // R10 slave mode 0 ignores VSYNC
    slave0 = 1;
    vsync_in = 1; tick(1); vsync_in = 0; tick(1);
    exp_pos("R10");
    tick(24 - n); exp_pos("R10");
    vcr_en = 0; slave0 = 0;
    // R7 / R8 serial control frame
    pin_mode = 2'b10;
    tick(1);
    step_phase("R7", 32'h0);
    v1 = 22'h2AB55;
    send_rtc(v1);
    tick(1);
    for (int w = 0; w < 20 && h_cnt != 3'd7; w++) tick(1);
    step_phase("R8", 32'h0);
    push("R8", 0, 0);
    step_phase("R7", {v1, 10'h0});
    step_phase("R7", {v1, 10'h0});
    pin_mode = 2'b11;
    step_phase("R5", cur_inc);
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule